// File: doc/BRIEF.md
# Reconfigurable ALU Bus Sequencer

This block moves operand and result words between an external memory stream and an array of processing elements that share one internal addressed bus. A small stored program, written by the host while the block is idle, decides each transfer: an external word may go to one element register, to one register-file slot, or to both in the same step; a register-file slot may be sent to an element; and an element result may be returned to the external stream or parked in the register file for later reuse. Every transfer completes through a valid/acknowledge handshake, and the sequencer waits on each handshake before moving to the next instruction, so external words are consumed in exactly program order.

Instructions are 24 bits: opcode in bits 23:20, register-file slot in bits 19:14, element register address in bits 13:6, branch target in bits 5:0. Opcodes: 0 stop, 1 external to element, 2 external to element and register file, 3 external to register file, 4 register file to element, 5 element to external output, 6 element to register file, 7 branch to target when the host flag is high; 8 to 15 do nothing and step on. The register file holds 64 words of 34 bits: a 32-bit value plus a 2-bit status tag, which is 01 for words taken from the external stream and whatever the element returned for array reads.

Top module: `rac_ctrl`

## Requirements
- R1: While reset is high and in the cycle after, `done`, `ab_req`, `ext_in_ready` and `ext_out_valid` are all low.
- R2: Program writes through `cfg_we` take effect only while the sequencer is stopped; a write arriving during a run leaves the stored program unchanged. `start` while stopped begins execution at instruction 0.
- R3: Opcode 1 accepts one external word, then requests an array write to the element address in bits 13:6 with data {2'b01, word}.
- R4: Opcode 2 behaves as opcode 1 and also stores {2'b01, word} into the register-file slot in bits 19:14 in the cycle the external word is accepted, adding no cycle to the transfer.
- R5: Opcode 4 requests an array write of the full 34-bit register-file slot to the addressed element.
- R6: Opcode 5 requests an array read from the addressed element, then presents the low 32 bits of the returned word on `ext_out_data` with `ext_out_valid` until `ext_out_ready`, holding the data stable.
- R7: Opcode 6 reads the addressed element and stores the returned 34-bit word, status bits included, in the register-file slot.
- R8: An array request, once raised, stays raised with unchanged address, direction and data until `ab_ack`; the program counter does not move meanwhile, so external words reach the array in program order.
- R9: Opcode 7 jumps to the target in bits 5:0 when `host_flag` is high and otherwise steps to the next instruction.
- R10: Opcode 0 stops the sequencer and raises `done`, which stays high with no bus activity until the next `start`, which clears it in the following cycle.
- R11: Opcode 3 stores the accepted external word in the register file without any array-bus request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Program memory write strobe |
| cfg_addr | input | 6 | Program memory write address |
| cfg_data | input | 24 | Instruction word to store |
| start | input | 1 | Begin execution from instruction 0 |
| host_flag | input | 1 | Host condition tested by the branch opcode |
| done | output | 1 | Program reached a stop instruction |
| ext_in_valid | input | 1 | External word available |
| ext_in_ready | output | 1 | External word accepted this cycle when valid |
| ext_in_data | input | 32 | External word |
| ext_out_valid | output | 1 | Result word available for the external side |
| ext_out_ready | input | 1 | External side takes the result |
| ext_out_data | output | 32 | Result word |
| ab_req | output | 1 | Array bus request |
| ab_we | output | 1 | Array bus direction, 1 for write |
| ab_addr | output | 8 | Element register address |
| ab_wdata | output | 34 | Array write word |
| ab_ack | input | 1 | Array acknowledge, completes the request |
| ab_rdata | input | 34 | Array read word, valid with the acknowledge |

## Verification
The hardest situation to reach is a transfer stalled on a slow acknowledge while the next instruction wants the other bus, because that is where a word could slip out of order or a request could change under the responder. The bench's array model acknowledges after a delay that varies from write to write and its output sink drops ready on alternate cycles, so every transfer kind stalls for different lengths. A program that mixes dual-destination loads, register-file reuse and array reads is run twice with the host flag flipped, and the full log of array writes is compared against an expected list in order.

// File: rtl/rac_pkg.sv
package rac_pkg;
    localparam int DATA_W   = 32;
    localparam int STAT_W   = 2;
    localparam int WORD_W   = DATA_W + STAT_W;
    localparam int RF_DEPTH = 64;
    localparam int RF_IDX_W = $clog2(RF_DEPTH);
    localparam int PM_DEPTH = 64;
    localparam int PC_W     = $clog2(PM_DEPTH);
    localparam int ELEM_W   = 8;
    localparam int OP_W     = 4;
    localparam int INSTR_W  = OP_W + RF_IDX_W + ELEM_W + PC_W;

    localparam logic [STAT_W-1:0] ST_EXT = 2'b01;

    typedef enum logic [OP_W-1:0] {
        OP_STOP   = 4'd0,
        OP_X2E    = 4'd1,
        OP_X2ER   = 4'd2,
        OP_X2R    = 4'd3,
        OP_R2E    = 4'd4,
        OP_E2X    = 4'd5,
        OP_E2R    = 4'd6,
        OP_BRHOST = 4'd7
    } op_e;

    typedef struct packed {
        logic [OP_W-1:0]     op;
        logic [RF_IDX_W-1:0] slot;
        logic [ELEM_W-1:0]   elem;
        logic [PC_W-1:0]     tgt;
    } instr_t;

    function automatic logic takes_ext(input logic [OP_W-1:0] op);
        return op == OP_X2E || op == OP_X2ER || op == OP_X2R;
    endfunction

    function automatic logic writes_rf_from_ext(input logic [OP_W-1:0] op);
        return op == OP_X2ER || op == OP_X2R;
    endfunction
endpackage

// File: rtl/rac_progmem.sv
module rac_progmem
    import rac_pkg::*;
#(
    parameter int DEPTH = PM_DEPTH,
    parameter int AW    = $clog2(DEPTH),
    parameter int W     = INSTR_W
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/rac_regfile.sv
module rac_regfile
    import rac_pkg::*;
#(
    parameter int DEPTH = RF_DEPTH,
    parameter int AW    = $clog2(DEPTH),
    parameter int W     = WORD_W
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] idx,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
    end

    assign rdata = mem[idx];
endmodule

// File: rtl/rac_addrgen.sv
module rac_addrgen
    import rac_pkg::*;
#(
    parameter int AW = ELEM_W
) (
    input  logic          req,
    input  logic [AW-1:0] elem,
    output logic [AW-1:0] addr
);
    // Drive the element address only while a request is on the bus.
    assign addr = req ? elem : '0;
endmodule

// File: rtl/rac_seq.sv
module rac_seq
    import rac_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                host_flag,
    input  logic [INSTR_W-1:0]  instr_word,
    output logic [PC_W-1:0]     pc,
    output logic                busy,
    output logic                done,
    input  logic                ext_in_valid,
    output logic                ext_in_ready,
    input  logic [DATA_W-1:0]   ext_in_data,
    output logic                ext_out_valid,
    input  logic                ext_out_ready,
    output logic [DATA_W-1:0]   ext_out_data,
    output logic                ab_req,
    output logic                ab_we,
    output logic [WORD_W-1:0]   ab_wdata,
    input  logic                ab_ack,
    input  logic [WORD_W-1:0]   ab_rdata,
    output logic [ELEM_W-1:0]   elem,
    output logic [RF_IDX_W-1:0] rf_idx,
    output logic                rf_we,
    output logic [WORD_W-1:0]   rf_wdata,
    input  logic [WORD_W-1:0]   rf_rdata
);
    instr_t            ins;
    logic              phase;
    logic [WORD_W-1:0] hold;
    logic              ext_fire, ab_fire, out_fire, advance;

    assign ins    = instr_t'(instr_word);
    assign elem   = ins.elem;
    assign rf_idx = ins.slot;

    always_comb begin
        ext_in_ready  = busy && !phase && takes_ext(ins.op);
        ab_req        = 1'b0;
        ab_we         = 1'b0;
        ab_wdata      = hold;
        ext_out_valid = 1'b0;
        if (busy) begin
            unique case (ins.op)
                OP_X2E, OP_X2ER: begin ab_req = phase;  ab_we = 1'b1; end
                OP_R2E:          begin ab_req = 1'b1;   ab_we = 1'b1; ab_wdata = rf_rdata; end
                OP_E2X:          begin ab_req = !phase; ext_out_valid = phase; end
                OP_E2R:          ab_req = 1'b1;
                default:         ;
            endcase
        end
    end

    assign ext_out_data = hold[DATA_W-1:0];
    assign ext_fire     = ext_in_ready && ext_in_valid;
    assign ab_fire      = ab_req && ab_ack;
    assign out_fire     = ext_out_valid && ext_out_ready;

    assign rf_we    = (writes_rf_from_ext(ins.op) && ext_fire) || (busy && ins.op == OP_E2R && ab_fire);
    assign rf_wdata = (ins.op == OP_E2R) ? ab_rdata : {ST_EXT, ext_in_data};

    always_comb begin
        advance = 1'b0;
        if (busy) begin
            unique case (ins.op)
                OP_STOP:         advance = 1'b0;
                OP_X2E, OP_X2ER: advance = phase && ab_fire;
                OP_X2R:          advance = ext_fire;
                OP_R2E, OP_E2R:  advance = ab_fire;
                OP_E2X:          advance = out_fire;
                default:         advance = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            pc    <= '0;
            phase <= 1'b0;
            hold  <= '0;
        end else if (!busy) begin
            if (start) begin
                busy  <= 1'b1;
                done  <= 1'b0;
                pc    <= '0;
                phase <= 1'b0;
            end
        end else if (ins.op == OP_STOP) begin
            busy <= 1'b0;
            done <= 1'b1;
        end else begin
            if (ext_fire && ins.op != OP_X2R) begin
                phase <= 1'b1;
                hold  <= {ST_EXT, ext_in_data};
            end else if (ins.op == OP_E2X && !phase && ab_fire) begin
                phase <= 1'b1;
                hold  <= ab_rdata;
            end
            if (advance) begin
                phase <= 1'b0;
                pc    <= (ins.op == OP_BRHOST && host_flag) ? ins.tgt : pc + 1'b1;
            end
        end
    end

    p_bus_hold_r8: assert property (@(posedge clk) disable iff (rst)
        ab_req && !ab_ack |=> ab_req && $stable(ab_we) && $stable(elem) && $stable(ab_wdata) && $stable(pc));

    p_out_hold_r6: assert property (@(posedge clk) disable iff (rst)
        ext_out_valid && !ext_out_ready |=> ext_out_valid && $stable(ext_out_data));

    p_stop_done_r10: assert property (@(posedge clk) disable iff (rst)
        busy && ins.op == OP_STOP |=> done && !busy);

    p_start_clears_r10: assert property (@(posedge clk) disable iff (rst)
        !busy && start |=> !done && busy);

    p_done_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> !ab_req && !ext_in_ready && !ext_out_valid);

    p_one_bus_r11: assert property (@(posedge clk) disable iff (rst)
        ext_in_ready |-> !ab_req);
endmodule

// File: rtl/rac_ctrl.sv
module rac_ctrl
    import rac_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [PC_W-1:0]     cfg_addr,
    input  logic [INSTR_W-1:0]  cfg_data,
    input  logic                start,
    input  logic                host_flag,
    output logic                done,
    input  logic                ext_in_valid,
    output logic                ext_in_ready,
    input  logic [DATA_W-1:0]   ext_in_data,
    output logic                ext_out_valid,
    input  logic                ext_out_ready,
    output logic [DATA_W-1:0]   ext_out_data,
    output logic                ab_req,
    output logic                ab_we,
    output logic [ELEM_W-1:0]   ab_addr,
    output logic [WORD_W-1:0]   ab_wdata,
    input  logic                ab_ack,
    input  logic [WORD_W-1:0]   ab_rdata
);
    logic [PC_W-1:0]     pc;
    logic [INSTR_W-1:0]  instr_word;
    logic                busy;
    logic [ELEM_W-1:0]   elem;
    logic [RF_IDX_W-1:0] rf_idx;
    logic                rf_we;
    logic [WORD_W-1:0]   rf_wdata, rf_rdata;

    rac_progmem u_prog (
        .clk   (clk),
        .we    (cfg_we && !busy),
        .waddr (cfg_addr),
        .wdata (cfg_data),
        .raddr (pc),
        .rdata (instr_word)
    );

    rac_regfile u_rf (
        .clk   (clk),
        .we    (rf_we),
        .idx   (rf_idx),
        .wdata (rf_wdata),
        .rdata (rf_rdata)
    );

    rac_addrgen u_agen (
        .req  (ab_req),
        .elem (elem),
        .addr (ab_addr)
    );

    rac_seq u_seq (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .host_flag     (host_flag),
        .instr_word    (instr_word),
        .pc            (pc),
        .busy          (busy),
        .done          (done),
        .ext_in_valid  (ext_in_valid),
        .ext_in_ready  (ext_in_ready),
        .ext_in_data   (ext_in_data),
        .ext_out_valid (ext_out_valid),
        .ext_out_ready (ext_out_ready),
        .ext_out_data  (ext_out_data),
        .ab_req        (ab_req),
        .ab_we         (ab_we),
        .ab_wdata      (ab_wdata),
        .ab_ack        (ab_ack),
        .ab_rdata      (ab_rdata),
        .elem          (elem),
        .rf_idx        (rf_idx),
        .rf_we         (rf_we),
        .rf_wdata      (rf_wdata),
        .rf_rdata      (rf_rdata)
    );

    p_cfg_locked_r2: assert property (@(posedge clk) disable iff (rst)
        busy && cfg_we |=> $stable(u_prog.mem[$past(cfg_addr)]));
endmodule

// File: tb/test_rac_ctrl.sv
module test_rac_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [23:0] cfg_data = '0;
    logic        start = 1'b0;
    logic        host_flag = 1'b0;
    logic        done;
    logic        ext_in_valid;
    logic        ext_in_ready;
    logic [31:0] ext_in_data;
    logic        ext_out_valid;
    logic        ext_out_ready = 1'b0;
    logic [31:0] ext_out_data;
    logic        ab_req, ab_we;
    logic [7:0]  ab_addr;
    logic [33:0] ab_wdata;
    logic        ab_ack = 1'b0;
    logic [33:0] ab_rdata = '0;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    rac_ctrl i_rac_ctrl (.*);

    function automatic logic [31:0] wsrc(input int i);
        return 32'hC0DE_0000 | i;
    endfunction

    function automatic logic [23:0] mk(input int op, input int slot, input int el, input int tgt);
        return {op[3:0], slot[5:0], el[7:0], tgt[5:0]};
    endfunction

    // Expected array writes over both runs: {address, word}.
    localparam int NW = 11;
    localparam logic [41:0] EXP_WR [NW] = '{
        {8'h10, 2'b01, 32'hC0DE_0000},
        {8'h11, 2'b01, 32'hC0DE_0001},
        {8'h20, 2'b01, 32'hC0DE_0001},
        {8'h21, 2'b01, 32'hC0DE_0002},
        {8'h22, 2'b10, 32'hA000_0031},
        {8'h12, 2'b01, 32'hC0DE_0003},
        {8'h10, 2'b01, 32'hC0DE_0004},
        {8'h11, 2'b01, 32'hC0DE_0005},
        {8'h20, 2'b01, 32'hC0DE_0005},
        {8'h21, 2'b01, 32'hC0DE_0006},
        {8'h22, 2'b10, 32'hA000_0031}
    };

    function automatic string wr_tag(input int i);
        case (i)
            0, 5, 6: return "R3 load to element";
            1, 7:    return "R4 dual load";
            2, 8:    return "R5 slot reuse after R4";
            3, 9:    return "R11 slot-only load then R5";
            4, 10:   return "R7 status kept";
            default: return "R8 order";
        endcase
    endfunction

    task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // External source.
    int in_idx = 0;
    assign ext_in_valid = (in_idx < 7);
    assign ext_in_data  = wsrc(in_idx);
    always @(posedge clk) if (ext_in_valid && ext_in_ready) in_idx <= in_idx + 1;

    // External sink, ready on alternate cycles.
    logic [31:0] out_log [4];
    int out_n = 0;
    always @(posedge clk) begin
        cycles <= cycles + 1;
        ext_out_ready <= cycles[0];
        if (ext_out_valid && ext_out_ready) begin
            if (out_n < 4) out_log[out_n] <= ext_out_data;
            out_n <= out_n + 1;
        end
    end

    // Array model with varying acknowledge delay.
    logic [33:0] amem [256];
    logic [41:0] wr_log [16];
    int wr_n = 0;
    int wait_c = 0;
    int req_n = 0;
    initial for (int i = 0; i < 256; i++) amem[i] = {2'b10, 32'hA000_0000 | i};
    always @(posedge clk) begin
        if (ab_req && ab_ack) begin
            ab_ack <= 1'b0;
            wait_c <= 0;
            req_n  <= req_n + 1;
            if (ab_we) begin
                amem[ab_addr] <= ab_wdata;
                if (wr_n < 16) wr_log[wr_n] <= {ab_addr, ab_wdata};
                wr_n <= wr_n + 1;
            end
        end else if (ab_req) begin
            if (wait_c >= req_n % 3) begin
                ab_ack   <= 1'b1;
                ab_rdata <= amem[ab_addr];
            end else begin
                wait_c <= wait_c + 1;
            end
        end
    end

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check(done === 1'b1, tag, {63'd0, done}, 64'd1);
    endtask

    task automatic finish_up;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!done && !ab_req && !ext_in_ready && !ext_out_valid, "R1 reset outputs",
              {60'd0, done, ab_req, ext_in_ready, ext_out_valid}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!done && !ab_req && !ext_in_ready && !ext_out_valid, "R1 after reset",
              {60'd0, done, ab_req, ext_in_ready, ext_out_valid}, 64'd0);

        for (int a = 0; a < 11; a++) begin
            cfg_we = 1'b1;
            cfg_addr = a[5:0];
            case (a)
                0:  cfg_data = mk(1, 0, 8'h10, 0);
                1:  cfg_data = mk(2, 5, 8'h11, 0);
                2:  cfg_data = mk(3, 9, 0, 0);
                3:  cfg_data = mk(4, 5, 8'h20, 0);
                4:  cfg_data = mk(4, 9, 8'h21, 0);
                5:  cfg_data = mk(5, 0, 8'h30, 0);
                6:  cfg_data = mk(6, 12, 8'h31, 0);
                7:  cfg_data = mk(4, 12, 8'h22, 0);
                8:  cfg_data = mk(7, 0, 0, 10);
                9:  cfg_data = mk(1, 0, 8'h12, 0);
                default: cfg_data = mk(0, 0, 0, 0);
            endcase
            @(negedge clk);
        end
        cfg_we = 1'b0;

        // Run 1, flag low: branch falls through (R9).
        host_flag = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R10 run one stops");
        check(in_idx == 4, "R9 flag low takes fall-through load", in_idx, 4);
        repeat (5) @(negedge clk);
        check(done && !ab_req && !ext_in_ready && !ext_out_valid, "R10 quiet after stop",
              {60'd0, done, ab_req, ext_in_ready, ext_out_valid}, 64'h8);

        // Run 2, flag high: branch skips the final load.
        host_flag = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!done, "R10 start clears done", {63'd0, done}, 64'd0);
        // Attempt to overwrite the stop instruction mid-run (R2).
        cfg_we = 1'b1;
        cfg_addr = 6'd10;
        cfg_data = mk(15, 0, 0, 0);
        @(negedge clk);
        cfg_we = 1'b0;
        wait_done("R2 program write during run ignored");
        check(in_idx == 7, "R9 flag high skips load", in_idx, 7);

        check(wr_n == NW, "R8 array write count", wr_n, NW);
        for (int i = 0; i < NW; i++) begin
            check(wr_log[i] === EXP_WR[i], wr_tag(i), {22'd0, wr_log[i]}, {22'd0, EXP_WR[i]});
        end
        check(out_n == 2, "R6 result count", out_n, 2);
        for (int i = 0; i < 2; i++) begin
            check(out_log[i] === 32'hA000_0030, "R6 element result to output",
                  {32'd0, out_log[i]}, 64'hA000_0030);
        end
        finish_up();
    end
endmodule